// File: doc/BRIEF.md
# Paged Hardware-Monitor Register Window

This block is the host-facing register file of a hardware-monitor function. It occupies 256 byte offsets above an I/O base decoded elsewhere. It is reached over a plain byte-wide bus that has an offset, write data, read data, a write strobe and a read strobe. Sixteen pages of monitor registers share one window of offsets, `0x10` to `0xFE`. A page-select byte at the top offset chooses which page that window shows.

Updates are guarded by a lock bit in a control byte. Software clears the lock, writes the paged registers it needs and then sets the lock again. That final 0-to-1 step tells the monitor core, through a one-cycle pulse, that the register contents have changed. Reads need no locking. One register in page 1 also drives the fan PWM duty output directly.

Top module: `hwm_paged_window`

## Requirements
- R1: After reset the lock bit reads 1, the page index reads 0, every paged register reads 0, `data_changed` is 0 and `fan_duty` is 0.
- R2: A write to an offset from 0x10 to 0xFE while the lock bit is 0 stores the byte in the currently selected page at that offset. A later read of the same page and offset returns it.
- R3: A write to an offset from 0x10 to 0xFE while the lock bit is 1 is ignored. The stored byte and `fan_duty` keep their values.
- R4: Offset 0x04 is the control byte. Only bit 0 (the lock bit) is stored. A read returns the lock bit in bit 0 and zeros in bits 7:1.
- R5: `data_changed` is high for exactly the one cycle after a write to 0x04 with data bit 0 = 1 while the lock bit was 0. A write that leaves the lock bit at 1, or that clears it, gives no pulse.
- R6: Offset 0xFF is the page index. Data bits 3:0 are stored and a read returns them with bits 7:4 as 0. The new page applies to the very next access.
- R7: The page index can be written whether the lock bit is 0 or 1.
- R8: Pages are independent: the same offset in two different pages holds two different bytes.
- R9: `fan_duty` always equals the byte at page 1, offset 0x98. It follows a write to that register on the cycle after the write.
- R10: Offsets 0x00–0x03 and 0x05–0x0F read as 0x00, and writes to them change no state.
- R11: `rdata` shows the addressed register combinationally while `rd_en` is 1, whatever the lock bit is, and is 0x00 while `rd_en` is 0. Reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| addr | input | 8 | Byte offset within the window |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid while `rd_en` is high |
| data_changed | output | 1 | One-cycle pulse when an update is committed |
| fan_duty | output | 8 | Fan PWM duty taken from page 1, offset 0x98 |

## Verification
The bench keeps its own model of the lock bit, the page index and a 16×256 byte image, and on every clock compares `rdata`, `fan_duty` and `data_changed` against that model.

- **Lock state:** identical paged writes are issued with the lock bit set and cleared, which separates a write gate that works from one that is missing or inverted.
- **Control writes:** writes to 0x04 go through 1→1, 1→0, 0→0 and 0→1, so only a true rising commit may pulse.
- **Page switches:** the page is changed and the very next cycle accesses a paged offset, which exposes a page select that lags by a cycle.
- **Page-tagged data:** every page is filled with distinct bytes at its two boundary offsets, which catches aliasing between pages or at the ends of the range.
- **Unmapped offsets:** the unmapped bytes are written with all ones and then read back.

// File: rtl/hwm_win_pkg.sv
package hwm_win_pkg;
  localparam int unsigned ADDR_W     = 8;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_PAGE   = 8'hFF;
  localparam logic [ADDR_W-1:0] OFF_WIN_LO = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_WIN_HI = 8'hFE;
  localparam int unsigned WIN_SLOTS  = int'(OFF_WIN_HI) - int'(OFF_WIN_LO) + 1;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_PAGE  = 2'd2,
    SEL_WIN   = 2'd3
  } sel_e;

  function automatic sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == OFF_CTRL)                        return SEL_CTRL;
    else if (a == OFF_PAGE)                   return SEL_PAGE;
    else if (a >= OFF_WIN_LO && a <= OFF_WIN_HI) return SEL_WIN;
    else                                      return SEL_NONE;
  endfunction
endpackage

// File: rtl/hwm_rst_sync.sv
module hwm_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/hwm_commit_ctrl.sv
module hwm_commit_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_wr_i,
  input  logic lock_bit_i,
  output logic lock_o,
  output logic changed_o
);
  logic lock_q, lock_d;
  logic changed_q, changed_d;

  always_comb begin
    lock_d    = lock_q;
    changed_d = 1'b0;
    if (ctrl_wr_i) begin
      lock_d    = lock_bit_i;
      changed_d = lock_bit_i & ~lock_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q    <= 1'b1;
      changed_q <= 1'b0;
    end else begin
      lock_q    <= lock_d;
      changed_q <= changed_d;
    end
  end

  assign lock_o    = lock_q;
  assign changed_o = changed_q;

  // R5: the pulse never lasts two cycles
  assert_pulse_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    changed_o |=> !changed_o);
  // R5: a pulse only follows an unlocked-to-locked step
  assert_pulse_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    changed_o |-> (lock_o && !$past(lock_o)));
endmodule

// File: rtl/hwm_page_sel.sv
module hwm_page_sel #(
  parameter int unsigned PAGE_CNT = 16,
  localparam int unsigned PAGE_W  = $clog2(PAGE_CNT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              page_wr_i,
  input  logic [PAGE_W-1:0] page_val_i,
  output logic [PAGE_W-1:0] page_o
);
  logic [PAGE_W-1:0] page_q, page_d;

  always_comb begin
    page_d = page_q;
    if (page_wr_i) page_d = page_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) page_q <= '0;
    else         page_q <= page_d;
  end

  assign page_o = page_q;

  // R6: a page write is visible on the following cycle
  assert_page_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_wr_i |=> (page_o == $past(page_val_i)));
endmodule

// File: rtl/hwm_page_store.sv
module hwm_page_store
  import hwm_win_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PAGE_CNT = 16,
  parameter int unsigned FAN_PAGE = 1,
  parameter logic [ADDR_W-1:0] FAN_OFF = 8'h98,
  localparam int unsigned PAGE_W  = $clog2(PAGE_CNT),
  localparam int unsigned IDX_W   = $clog2(WIN_SLOTS),
  localparam int unsigned FAN_IDX = int'(FAN_OFF) - int'(OFF_WIN_LO)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] fan_o
);
  logic [DATA_W-1:0] mem_q [PAGE_CNT][WIN_SLOTS];
  logic [ADDR_W-1:0] off_rel;
  logic [IDX_W-1:0]  idx;

  assign off_rel = addr_i - OFF_WIN_LO;
  assign idx     = off_rel[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < int'(PAGE_CNT); p++)
        for (int s = 0; s < int'(WIN_SLOTS); s++)
          mem_q[p][s] <= '0;
    end else if (wr_en_i) begin
      mem_q[page_i][idx] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[page_i][idx];
  assign fan_o   = mem_q[FAN_PAGE][FAN_IDX];
endmodule

// File: rtl/hwm_paged_window.sv
module hwm_paged_window
  import hwm_win_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PAGE_CNT = 16,
  parameter int unsigned FAN_PAGE = 1,
  parameter logic [7:0]  FAN_OFF  = 8'h98,
  localparam int unsigned PAGE_W  = $clog2(PAGE_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              data_changed,
  output logic [DATA_W-1:0] fan_duty
);
  logic              rst_int_n;
  sel_e              sel;
  logic              lock;
  logic [PAGE_W-1:0] page;
  logic [DATA_W-1:0] win_rdata;
  logic              win_wr, ctrl_wr, page_wr;

  assign sel     = decode(addr);
  assign ctrl_wr = wr_en && (sel == SEL_CTRL);
  assign page_wr = wr_en && (sel == SEL_PAGE);
  assign win_wr  = wr_en && (sel == SEL_WIN) && !lock;

  hwm_rst_sync u_rst (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_int_n)
  );

  hwm_commit_ctrl u_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_int_n),
    .ctrl_wr_i  (ctrl_wr),
    .lock_bit_i (wdata[0]),
    .lock_o     (lock),
    .changed_o  (data_changed)
  );

  hwm_page_sel #(.PAGE_CNT(PAGE_CNT)) u_page (
    .clk_i      (clk),
    .rst_ni     (rst_int_n),
    .page_wr_i  (page_wr),
    .page_val_i (wdata[PAGE_W-1:0]),
    .page_o     (page)
  );

  hwm_page_store #(
    .DATA_W   (DATA_W),
    .PAGE_CNT (PAGE_CNT),
    .FAN_PAGE (FAN_PAGE),
    .FAN_OFF  (FAN_OFF)
  ) u_store (
    .clk_i   (clk),
    .rst_ni  (rst_int_n),
    .wr_en_i (win_wr),
    .page_i  (page),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (win_rdata),
    .fan_o   (fan_duty)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_CTRL: rdata = {{(DATA_W-1){1'b0}}, lock};
        SEL_PAGE: rdata = {{(DATA_W-PAGE_W){1'b0}}, page};
        SEL_WIN:  rdata = win_rdata;
        default:  rdata = '0;
      endcase
    end
  end

  // R3: a blocked write leaves the fan duty untouched
  assert_locked_fan_hold_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    lock |=> $stable(fan_duty));
  // R10: unmapped offsets read as zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && addr < 8'h10 && addr != 8'h04) |-> (rdata == '0));
  // R11: no read strobe, no read data
  assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_en |-> (rdata == '0));
  // R6: upper page bits read as zero
  assert_page_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && addr == 8'hFF) |-> (rdata[7:4] == 4'h0));
endmodule

// File: tb/hwm_paged_window_tb_top.sv
`timescale 1ns/1ps
module hwm_paged_window_tb_top;
  logic       clk;
  logic       rst_n;
  logic [7:0] addr, wdata, rdata, fan_duty;
  logic       wr_en, rd_en, data_changed;

  int checks = 0;
  int fails  = 0;

  // behavioural model
  byte unsigned mm [16][256];
  bit           m_lock;
  int           m_page;
  bit           m_dc;

  hwm_paged_window dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .data_changed(data_changed), .fan_duty(fan_duty)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int model_read(int a);
    if (a == 8'h04) return int'(m_lock);
    if (a == 8'hFF) return m_page;
    if (a >= 8'h10 && a <= 8'hFE) return int'(mm[m_page][a]);
    return 0;
  endfunction

  task automatic cyc(bit w, bit r, int a, int d, string req);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = 8'(a); wdata = 8'(d);
    #1;
    if (r) check(req, rdata, model_read(a));
    else   check("R11 idle", rdata, 0);
    check("R9 fan", fan_duty, int'(mm[1][8'h98]));
    check("R5 pulse", data_changed, int'(m_dc));
    @(posedge clk);
    m_dc = w && a == 8'h04 && !m_lock && d[0];
    if (w) begin
      if (a == 8'h04) m_lock = d[0];
      else if (a == 8'hFF) m_page = d & 15;
      else if (a >= 8'h10 && a <= 8'hFE && !m_lock) mm[m_page][a] = 8'(d);
    end
  endtask

  task automatic wr(int a, int d, string req); cyc(1, 0, a, d, req); endtask
  task automatic rd(int a, string req);        cyc(0, 1, a, 0, req); endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    foreach (mm[p, s]) mm[p][s] = 0;
    m_lock = 1; m_page = 0; m_dc = 0;
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(8'h04, "R1 lock");
    rd(8'hFF, "R1 page");
    rd(8'h10, "R1 low");
    rd(8'h98, "R1 fan reg");
    rd(8'hFE, "R1 high");

    // R3 locked write ignored
    wr(8'h20, 8'hAA, "R3");
    rd(8'h20, "R3 locked");
    // R5 1->1 no pulse, then unlock
    wr(8'h04, 8'h01, "R5 1to1");
    wr(8'h04, 8'h00, "R5 unlock");
    wr(8'h04, 8'h00, "R5 0to0");
    rd(8'h04, "R4 unlocked");
    // R2
    wr(8'h20, 8'h5A, "R2");
    rd(8'h20, "R2 readback");
    // R6 immediate page switch, R9 fan
    wr(8'hFF, 8'hF1, "R6");
    wr(8'h98, 8'h80, "R6 R9 next access");
    rd(8'hFF, "R6 upper zero");
    wr(8'h20, 8'h33, "R8");
    rd(8'h20, "R8 page1");
    wr(8'hFF, 8'h00, "R6");
    rd(8'h20, "R8 page0");
    rd(8'h98, "R8 page0 fan slot");
    // R10 unmapped
    for (int a = 0; a < 16; a++) if (a != 4) wr(a, 8'hFF, "R10");
    for (int a = 0; a < 16; a++) if (a != 4) rd(a, "R10 read");
    rd(8'h04, "R10 ctrl untouched");
    // R4 upper ctrl bits not stored
    wr(8'h04, 8'hFE, "R4");
    rd(8'h04, "R4 readback");
    // page-tagged fill, boundary offsets
    for (int p = 0; p < 16; p++) begin
      wr(8'hFF, p, "R6");
      wr(8'h10, p * 17 + 1, "R2 low");
      wr(8'hFE, 8'hF0 ^ p, "R2 high");
    end
    for (int p = 15; p >= 0; p--) begin
      wr(8'hFF, p, "R6");
      rd(8'h10, "R8 low");
      rd(8'hFE, "R8 high");
    end
    // R5 commit
    wr(8'h04, 8'h01, "R5 commit");
    rd(8'h04, "R5 pulse cycle");
    wr(8'h04, 8'h03, "R5 no repeat");
    rd(8'h04, "R4 locked");
    // R3 locked fan write, R7 page write while locked, R11 locked reads
    wr(8'hFF, 8'h01, "R7");
    rd(8'hFF, "R7 readback");
    wr(8'h98, 8'h11, "R3 fan");
    rd(8'h98, "R11 locked read");
    rd(8'h20, "R11 locked read");
    // second commit round
    wr(8'h04, 8'h00, "R5");
    wr(8'h98, 8'hC3, "R9");
    wr(8'h04, 8'h01, "R5 commit2");
    rd(8'h98, "R9 readback");
    cyc(0, 0, 0, 0, "R11");
    cyc(0, 0, 0, 0, "R11");
    finish_run();
  end
endmodule